// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A requester presents a virtual address and the kind of access it wants (read, write or execute). The walker takes the top ten address bits as an index into the page directory. The directory's physical page comes from a per-process root page number input. The walker reads that directory entry, then uses the middle ten bits to index the second-level table that the directory entry names. It reads the leaf entry, checks its valid and permission bits, and reports either a physical address or a two-bit fault code. With the fault code it returns the last entry it read.

The walk is a state machine with six states. From IDLE, an accepted request moves the walker to READ_DIR, which issues the directory read. READ_DIR always moves to WAIT_DIR. In WAIT_DIR a response with the valid bit clear moves to DONE, and a valid response moves to READ_LEAF, which issues the leaf read. READ_LEAF always moves to WAIT_LEAF. WAIT_LEAF moves to DONE when the response arrives. DONE always returns to IDLE. Memory is reached through a single-outstanding read port: a one-cycle read strobe with an address, then a response strobe with the data after any number of cycles.

An entry is 32 bits wide. Bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute, bit 4 is dirty, and bits 31:12 hold a page number. In a directory entry that page number is the page holding the second-level table. In a leaf entry it is the physical page of the data.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and rsp_done_o and mem_rd_o are 0.
- R2: A request is accepted only on a rising edge in IDLE with req_valid_i high. req_ready_o is 0 from the cycle after acceptance through the DONE cycle, so requests held during a walk wait.
- R3: The directory read strobe is high for exactly the one cycle after acceptance. Its address is root page number times 4096 plus virtual bits 31:22 times 4.
- R4: The leaf read strobe is high for exactly the one cycle after a valid directory response. Its address is the directory entry's bits 31:12 times 4096 plus virtual bits 21:12 times 4.
- R5: A directory entry with bit 0 clear ends the walk with fault code 01. No leaf read is issued, and the returned entry is the directory entry.
- R6: A leaf entry with bit 0 clear gives fault code 10.
- R7: For a valid leaf, access code 00 (read) needs bit 1, code 01 (write) needs bit 2, and code 10 (execute) needs bit 3. Code 11 is never permitted. A missing permission gives fault code 11.
- R8: With fault code 00, the physical address is the leaf's bits 31:12 followed by virtual bits 11:0, and the returned entry is the leaf. With any fault, the physical address is 0.
- R9: rsp_done_o is high for exactly one cycle: the cycle after the response that ends the walk. req_ready_o returns to 1 in the following cycle.
- R10: At most one read is outstanding. A response strobe outside WAIT_DIR and WAIT_LEAF, including one in IDLE, is ignored.
- R11: The address, access code and root page number are captured on acceptance. Changing them during a walk has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn_i | input | 20 | Physical page of the page directory for the current process |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_access_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | 32 | Physical address of the entry to read |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| rsp_done_o | output | 1 | One-cycle result strobe |
| rsp_fault_o | output | 2 | 00 none, 01 directory invalid, 10 leaf invalid, 11 permission |
| rsp_paddr_o | output | 32 | Translated physical address, 0 on fault |
| rsp_entry_o | output | 32 | Last entry read by the walk |

## Verification
A request accepted on a rising edge drives the directory read strobe in the next cycle. A response arriving on edge k drives the leaf read strobe in cycle k+1, or raises done in cycle k+1 if the directory entry is invalid. The leaf response drives done and the result one cycle later, and ready returns the cycle after that. The bench's behavioural model moves through these timings on each rising edge from the inputs the bench itself drives. At every falling edge it compares ready, the read strobe, the address and the result against the model. Memory latency is varied from one to four cycles so that every waiting interval is exercised.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_LEAF,
        ST_WAIT_LEAF,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } access_e;

    localparam logic [1:0] FLT_NONE      = 2'b00;
    localparam logic [1:0] FLT_DIR_INV   = 2'b01;
    localparam logic [1:0] FLT_LEAF_INV  = 2'b10;
    localparam logic [1:0] FLT_PERM      = 2'b11;

    localparam int BIT_VALID = 0;
    localparam int BIT_READ  = 1;
    localparam int BIT_WRITE = 2;
    localparam int BIT_EXEC  = 3;
    localparam int FLAG_W    = 4;

endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        rvalid,
    input  logic        dir_invalid,
    output walk_state_e state,
    output logic        ready,
    output logic        rd_strobe,
    output logic        leaf_sel,
    output logic        dir_hit,
    output logic        leaf_hit,
    output logic        done
);

    walk_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_d = ST_READ_DIR;
            ST_READ_DIR:  state_d = ST_WAIT_DIR;
            ST_WAIT_DIR:  if (rvalid) state_d = dir_invalid ? ST_DONE : ST_READ_LEAF;
            ST_READ_LEAF: state_d = ST_WAIT_LEAF;
            ST_WAIT_LEAF: if (rvalid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = (state == ST_IDLE);
        rd_strobe = (state == ST_READ_DIR) || (state == ST_READ_LEAF);
        leaf_sel  = (state == ST_READ_LEAF);
        dir_hit   = (state == ST_WAIT_DIR) && rvalid;
        leaf_hit  = (state == ST_WAIT_LEAF) && rvalid;
        done      = (state == ST_DONE);
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        access,
    input  logic              is_leaf,
    output logic [1:0]        fault
);

    logic allowed;

    always_comb begin
        unique case (access)
            ACC_READ:  allowed = flags[BIT_READ];
            ACC_WRITE: allowed = flags[BIT_WRITE];
            ACC_EXEC:  allowed = flags[BIT_EXEC];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!flags[BIT_VALID])          fault = is_leaf ? FLT_LEAF_INV : FLT_DIR_INV;
        else if (is_leaf && !allowed)   fault = FLT_PERM;
        else                            fault = FLT_NONE;
    end

endmodule

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PPN_W = 20,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [PPN_W-1:0] table_ppn,
    input  logic [IDX_W-1:0] dir_idx,
    input  logic [IDX_W-1:0] leaf_idx,
    input  logic             leaf_sel,
    output logic [PA_W-1:0]  addr
);

    localparam int PAD_W = PA_W - IDX_W - 2;

    logic [PPN_W-1:0] base_ppn;
    logic [IDX_W-1:0] idx;

    always_comb begin
        base_ppn = leaf_sel ? table_ppn : root_ppn;
        idx      = leaf_sel ? leaf_idx : dir_idx;
        addr     = {base_ppn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PPN_W = 20,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int ENT_W = PPN_W + OFF_W,
    localparam int VA_W  = 2 * IDX_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_ppn_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_access_i,
    output logic             mem_rd_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic [ENT_W-1:0] mem_rdata_i,
    output logic             rsp_done_o,
    output logic [1:0]       rsp_fault_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic [ENT_W-1:0] rsp_entry_o
);

    walk_state_e      state;
    logic             ready, leaf_sel, dir_hit, leaf_hit;
    logic             dir_invalid;
    logic [1:0]       chk_fault;
    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       acc_q;
    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] table_q;
    logic [1:0]       fault_q;
    logic [PA_W-1:0]  paddr_q;
    logic [ENT_W-1:0] entry_q;

    pt_walk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid_i),
        .rvalid      (mem_rvalid_i),
        .dir_invalid (dir_invalid),
        .state       (state),
        .ready       (ready),
        .rd_strobe   (mem_rd_o),
        .leaf_sel    (leaf_sel),
        .dir_hit     (dir_hit),
        .leaf_hit    (leaf_hit),
        .done        (rsp_done_o)
    );

    pt_walk_addr #(.OFF_W(OFF_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_addr (
        .root_ppn  (root_q),
        .table_ppn (table_q),
        .dir_idx   (vaddr_q[VA_W-1 -: IDX_W]),
        .leaf_idx  (vaddr_q[OFF_W +: IDX_W]),
        .leaf_sel  (leaf_sel),
        .addr      (mem_addr_o)
    );

    pt_entry_check u_check (
        .flags   (mem_rdata_i[FLAG_W-1:0]),
        .access  (acc_q),
        .is_leaf (state == ST_WAIT_LEAF),
        .fault   (chk_fault)
    );

    assign dir_invalid = (chk_fault == FLT_DIR_INV);
    assign req_ready_o = ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            acc_q   <= '0;
            root_q  <= '0;
            table_q <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
            entry_q <= '0;
        end else begin
            if (ready && req_valid_i) begin
                vaddr_q <= req_vaddr_i;
                acc_q   <= req_access_i;
                root_q  <= root_ppn_i;
            end
            if (dir_hit) begin
                table_q <= mem_rdata_i[ENT_W-1:OFF_W];
                if (dir_invalid) begin
                    fault_q <= FLT_DIR_INV;
                    paddr_q <= '0;
                    entry_q <= mem_rdata_i;
                end
            end
            if (leaf_hit) begin
                fault_q <= chk_fault;
                entry_q <= mem_rdata_i;
                paddr_q <= (chk_fault == FLT_NONE) ?
                           {mem_rdata_i[ENT_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;
            end
        end
    end

    assign rsp_fault_o = fault_q;
    assign rsp_paddr_o = paddr_q;
    assign rsp_entry_o = entry_q;

    assert_leaf_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_LEAF) |-> mem_addr_o[PA_W-1:OFF_W] == $past(mem_rdata_i[ENT_W-1:OFF_W]));

    assert_dir_fault_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done_o && rsp_fault_o == FLT_DIR_INV) |-> !rsp_entry_o[BIT_VALID]);

    assert_perm_valid_leaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done_o && rsp_fault_o == FLT_PERM) |-> rsp_entry_o[BIT_VALID]);

    assert_ok_paddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done_o && rsp_fault_o == FLT_NONE) |->
            (rsp_paddr_o[PA_W-1:OFF_W] == rsp_entry_o[ENT_W-1:OFF_W]));

    assert_fault_zero_paddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done_o && rsp_fault_o != FLT_NONE) |-> (rsp_paddr_o == '0));

    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_DIR || state == ST_WAIT_LEAF) |-> !mem_rd_o);

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_ppn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_entry;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pt_walker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .root_ppn_i   (root_ppn),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_vaddr_i  (req_vaddr),
        .req_access_i (req_access),
        .mem_rd_o     (mem_rd),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .rsp_done_o   (rsp_done),
        .rsp_fault_o  (rsp_fault),
        .rsp_paddr_o  (rsp_paddr),
        .rsp_entry_o  (rsp_entry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural memory
    logic [31:0] mem [int unsigned];
    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    int lat_cfg = 1;
    int pend = 0;
    logic [31:0] pend_addr;
    bit spur = 0;

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_mem(pend_addr);
            end
        end else if (spur) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= 32'h0000_0000;
        end
        if (mem_rd) begin
            pend = lat_cfg;
            pend_addr = mem_addr;
        end
    end

    // reference model: phases 0 idle, 1 dir read, 2 dir wait, 3 leaf read, 4 leaf wait, 5 result
    int          ph = 0;
    logic [31:0] m_va;
    logic [1:0]  m_acc;
    logic [19:0] m_root;
    logic [31:0] m_pde, m_ent, m_paddr;
    logic [1:0]  m_fault;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
        end else begin
            case (ph)
                0: if (req_valid) begin
                       m_va = req_vaddr; m_acc = req_access; m_root = root_ppn; ph = 1;
                   end
                1: ph = 2;
                2: if (mem_rvalid) begin
                       m_pde = mem_rdata;
                       if (!m_pde[0]) begin
                           m_fault = 2'b01; m_ent = m_pde; m_paddr = 0; ph = 5;
                       end else ph = 3;
                   end
                3: ph = 4;
                4: if (mem_rvalid) begin
                       bit ok;
                       m_ent = mem_rdata;
                       case (m_acc)
                           2'b00: ok = m_ent[1];
                           2'b01: ok = m_ent[2];
                           2'b10: ok = m_ent[3];
                           default: ok = 0;
                       endcase
                       if (!m_ent[0])  m_fault = 2'b10;
                       else if (!ok)   m_fault = 2'b11;
                       else            m_fault = 2'b00;
                       m_paddr = (m_fault == 2'b00) ? {m_ent[31:12], m_va[11:0]} : 32'h0;
                       ph = 5;
                   end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 ready", {31'b0, req_ready}, {31'b0, ph == 0});
            chk("R3 R10 read strobe", {31'b0, mem_rd}, {31'b0, (ph == 1) || (ph == 3)});
            if (ph == 1)
                chk("R3 directory address", mem_addr, {m_root, 12'h000} + {20'h0, m_va[31:22], 2'b00});
            if (ph == 3)
                chk("R4 leaf address", mem_addr, {m_pde[31:12], 12'h000} + {20'h0, m_va[21:12], 2'b00});
            chk("R9 done", {31'b0, rsp_done}, {31'b0, ph == 5});
            if (ph == 5) begin
                chk("R5 R6 R7 fault code", {30'b0, rsp_fault}, {30'b0, m_fault});
                chk("R8 R11 physical address", rsp_paddr, m_paddr);
                chk("R5 R8 returned entry", rsp_entry, m_ent);
            end
        end
    end

    task automatic walk(input logic [19:0] root, input logic [31:0] va,
                        input logic [1:0] acc, input int lat);
        @(negedge clk);
        lat_cfg    = lat;
        root_ppn   = root;
        req_vaddr  = va;
        req_access = acc;
        req_valid  = 1'b1;
        @(negedge clk);
        // R11: disturb captured inputs, keep request pending (R2 back-pressure)
        root_ppn   = ~root;
        req_vaddr  = ~va;
        req_access = ~acc;
        while (!rsp_done) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] va_of(input int d, input int l, input int off);
        return {d[9:0], l[9:0], off[11:0]};
    endfunction

    initial begin
        // process A: root page 0x00010
        mem[32'h0001_0000 + 1*4] = 32'h0002_0001;
        mem[32'h0001_0000 + 2*4] = 32'h0007_0000;
        mem[32'h0002_0000 + 3*4] = 32'hABCD_E003;
        mem[32'h0002_0000 + 4*4] = 32'h1234_501F;
        mem[32'h0002_0000 + 5*4] = 32'h7777_700E;
        mem[32'h0002_0000 + 6*4] = 32'h4444_4009;
        mem[32'h0002_0000 + 7*4] = 32'h3333_3005;
        // process B: root page 0x00030
        mem[32'h0003_0000 + 1*4] = 32'h0004_0001;
        mem[32'h0004_0000 + 3*4] = 32'h5555_5007;

        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'b0, req_ready}, 32'h1);
        chk("R1 done in reset", {31'b0, rsp_done}, 32'h0);
        chk("R1 read in reset", {31'b0, mem_rd}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);

        walk(20'h00010, va_of(1, 3, 12'habc), 2'b00, 1);   // R8 read ok
        walk(20'h00010, va_of(1, 3, 12'h123), 2'b01, 2);   // R7 write denied
        walk(20'h00010, va_of(1, 3, 12'h000), 2'b10, 3);   // R7 exec denied
        walk(20'h00010, va_of(1, 4, 12'hfff), 2'b00, 1);   // R8
        walk(20'h00010, va_of(1, 4, 12'h800), 2'b01, 4);   // R8 write ok
        walk(20'h00010, va_of(1, 4, 12'h001), 2'b10, 2);   // R8 exec ok
        walk(20'h00010, va_of(1, 4, 12'h001), 2'b11, 1);   // R7 reserved code
        walk(20'h00010, va_of(1, 5, 12'h010), 2'b00, 3);   // R6 leaf invalid
        walk(20'h00010, va_of(2, 0, 12'h010), 2'b00, 2);   // R5 directory invalid
        walk(20'h00010, va_of(0, 0, 12'h000), 2'b00, 1);   // R5 unmapped entry
        walk(20'h00010, va_of(1, 6, 12'h044), 2'b10, 1);   // R8 exec-only ok
        walk(20'h00010, va_of(1, 6, 12'h044), 2'b00, 4);   // R7 exec-only read
        walk(20'h00010, va_of(1, 7, 12'h3c0), 2'b01, 2);   // R7 write-only ok
        walk(20'h00030, va_of(1, 3, 12'h5a5), 2'b01, 3);   // R3 second root

        // R10: response strobes while idle must be ignored
        spur = 1;
        repeat (4) @(negedge clk);
        spur = 0;
        @(negedge clk);
        chk("R10 no result from stray response", {31'b0, rsp_done}, 32'h0);
        chk("R10 still idle", {31'b0, req_ready}, 32'h1);
        walk(20'h00010, va_of(1, 4, 12'h2b2), 2'b00, 1);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule